// File: doc/BRIEF.md
# Pulse-Capture Timer Channel

A single timer channel with two jobs. In its waveform modes it counts prescaled clock ticks up to a programmed period and drives a pulse-width output. It runs either once or repeatedly. In capture mode it times the input instead. At every level change of the input it stores the length of the phase that just ended. A high phase goes to one register and a low phase to another. It also raises a flag that records the new input level, so software can rebuild an incoming pulse train, such as an infrared remote frame, from a series of interrupts.

The channel is programmed through a small register bus with a write strobe and a combinational read. The interrupt output is the status flag gated by an enable bit.

Top module: `pulse_timer`

## Requirements
- R1: While control bit 0 (enable) is 0, the counter keeps its value and capture edges set no status flag.
- R2: Control bits [2:1] select the mode. 00 is one-shot: the counter runs through one period and then clears bit 0 by itself. 01 is continuous: the counter wraps to 0 after reaching period-1 and keeps running. 10 is capture.
- R3: In the waveform modes with enable set, `pwm_out` equals control bit 3 while the counter is below the low/duty register, and its inverse otherwise. When the channel is disabled or in capture mode, `pwm_out` equals control bit 4.
- R4: With control bit 9 clear, the counter advances on every clock. With bit 9 set, it advances once every 2^N clocks, where N is control bits [14:12].
- R5: The input passes through two synchronizing flops before edge detection. On each detected edge in capture mode, the count of the phase that ended is stored in the high register (0x04) if the previous level was 1, or in the low register (0x08) if it was 0. The counter then restarts at 0.
- R6: In the status register (0x10), bit 0 is a flag set on every capture edge and bit 8 is the input level after that edge. Writing 1 to bit 0 clears the flag, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R7: `irq` is high exactly when the status flag and bit 0 of the interrupt enable register (0x14) are both set.
- R8: Register map: 0x00 is the counter (read-only), 0x04 is the period/high register, 0x08 is the duty/low register and 0x0C is control. The period and duty values are 16 bits wide.
- R9: In capture mode the counter stops at 0xFFFF instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| cap_in | input | 1 | Waveform to be measured |
| pwm_out | output | 1 | Generated waveform |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the saturated capture counter. The input must stay steady for more than 65535 ticks, so the stimulus leaves the channel in capture mode with a constant input for 66000 clocks and then produces an edge to latch the 0xFFFF value. A second hard case is the one-shot self-disable: the bench reads back the control register after the period to see bit 0 cleared by the hardware. A behavioural model predicts the output and the interrupt on every clock. It also predicts the register contents at each read, including the synchronizer delay between an input change and its capture.

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          cap_in,
  output logic          pwm_out,
  output logic          irq
);
  localparam int PW = (1 << DIV_W) - 1;
  localparam logic [AW-1:0] A_CNT = AW'(8'h00);
  localparam logic [AW-1:0] A_HI  = AW'(8'h04);
  localparam logic [AW-1:0] A_LO  = AW'(8'h08);
  localparam logic [AW-1:0] A_CTL = AW'(8'h0C);
  localparam logic [AW-1:0] A_ISR = AW'(8'h10);
  localparam logic [AW-1:0] A_IER = AW'(8'h14);

  logic             en, dpol, ipol, scale, ier, flag, pol;
  logic [1:0]       mode;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt, hi_r, lo_r;
  logic [PW-1:0]    pre, pre_lim;
  logic             s1, s2, s3;

  wire wr      = bus_sel & bus_wr;
  wire pwm_md  = ~mode[1];
  wire cap_md  = (mode == 2'b10);
  wire cap_ev  = en & cap_md & (s2 ^ s3);
  wire wrap    = ({1'b0, cnt} + 1'b1) >= {1'b0, hi_r};

  assign pre_lim = ~({PW{1'b1}} << div);
  wire tick = ~scale | (pre == pre_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      {en, dpol, ipol, scale, ier, flag, pol} <= '0;
      mode <= '0;
      div  <= '0;
      cnt  <= '0;
      hi_r <= '0;
      lo_r <= '0;
      pre  <= '0;
    end else begin
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
      pre <= (!en || tick) ? '0 : pre + 1'b1;
      if (en) begin
        if (pwm_md && tick) begin
          if (wrap) begin
            cnt <= '0;
            if (mode == 2'b00) en <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end else if (cap_ev) cnt <= '0;
        else if (cap_md && tick && cnt != '1) cnt <= cnt + 1'b1;
      end
      if (wr && bus_addr == A_CTL) begin
        en    <= bus_wdata[0];
        mode  <= bus_wdata[2:1];
        dpol  <= bus_wdata[3];
        ipol  <= bus_wdata[4];
        scale <= bus_wdata[9];
        div   <= bus_wdata[12 +: DIV_W];
      end
      if (wr && bus_addr == A_HI) hi_r <= bus_wdata[CNT_W-1:0];
      if (cap_ev && s3)          hi_r <= cnt;
      if (wr && bus_addr == A_LO) lo_r <= bus_wdata[CNT_W-1:0];
      if (cap_ev && !s3)         lo_r <= cnt;
      if (wr && bus_addr == A_IER) ier <= bus_wdata[0];
      if (wr && bus_addr == A_ISR && bus_wdata[0]) flag <= 1'b0;
      if (cap_ev) begin
        flag <= 1'b1;
        pol  <= s2;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT: bus_rdata[CNT_W-1:0] = cnt;
      A_HI:  bus_rdata[CNT_W-1:0] = hi_r;
      A_LO:  bus_rdata[CNT_W-1:0] = lo_r;
      A_CTL: begin
        bus_rdata[0]   = en;
        bus_rdata[2:1] = mode;
        bus_rdata[3]   = dpol;
        bus_rdata[4]   = ipol;
        bus_rdata[9]   = scale;
        bus_rdata[12 +: DIV_W] = div;
      end
      A_ISR: begin
        bus_rdata[0] = flag;
        bus_rdata[8] = pol;
      end
      A_IER: bus_rdata[0] = ier;
      default: bus_rdata = '0;
    endcase
  end

  assign pwm_out = (en && pwm_md) ? ((cnt < lo_r) ? dpol : ~dpol) : ipol;
  assign irq     = flag & ier;
endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic             s2,
  input logic             s3,
  input logic             flag,
  input logic             ier,
  input logic             irq
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
  p_noevt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flag) |=> !flag);
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b10 && s2 != s3) |=> cnt == '0);
  p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b10 && s2 != s3) |=> flag);
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag) && ier) |-> irq);
  p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b10 && cnt == '1 && s2 == s3) |=> cnt == '1);
endmodule

bind pulse_timer pulse_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cnt(cnt),
  .s2(s2), .s3(s3), .flag(flag), .ier(ier), .irq(irq)
);

// File: tb/pulse_timer_tb.sv
module pulse_timer_tb;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, cap_in = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic pwm_out, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  pulse_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq));

  always #10 clk = ~clk;

  int m_en, m_mode, m_dpol, m_ipol, m_scale, m_div, m_cnt, m_hi, m_lo;
  int m_pre, m_flag, m_pol, m_ier, m_s1, m_s2, m_s3;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_en, m_mode, m_dpol, m_ipol, m_scale, m_div, m_cnt, m_hi} = '0;
      {m_lo, m_pre, m_flag, m_pol, m_ier, m_s1, m_s2, m_s3} = '0;
    end else begin
      int ncnt, nen, nhi, nlo, nflag, npol, npre;
      bit tick, cap, w;
      tick = !m_scale || m_pre == ((1 << m_div) - 1);
      cap = m_en && m_mode == 2 && m_s2 != m_s3;
      w = bus_sel && bus_wr;
      npre = (!m_en || tick) ? 0 : m_pre + 1;
      ncnt = m_cnt; nen = m_en; nhi = m_hi; nlo = m_lo; nflag = m_flag; npol = m_pol;
      if (m_en) begin
        if (m_mode < 2 && tick) begin
          if (m_cnt + 1 >= m_hi) begin ncnt = 0; if (m_mode == 0) nen = 0; end
          else ncnt = m_cnt + 1;
        end else if (cap) ncnt = 0;
        else if (m_mode == 2 && tick && m_cnt != 65535) ncnt = m_cnt + 1;
      end
      if (w && bus_addr == 8'h0C) begin
        nen = bus_wdata[0]; m_mode = bus_wdata[2:1]; m_dpol = bus_wdata[3];
        m_ipol = bus_wdata[4]; m_scale = bus_wdata[9]; m_div = bus_wdata[14:12];
      end
      if (w && bus_addr == 8'h04) nhi = bus_wdata[15:0];
      if (w && bus_addr == 8'h08) nlo = bus_wdata[15:0];
      if (cap && m_s3) nhi = m_cnt;
      if (cap && !m_s3) nlo = m_cnt;
      if (w && bus_addr == 8'h14) m_ier = bus_wdata[0];
      if (w && bus_addr == 8'h10 && bus_wdata[0]) nflag = 0;
      if (cap) begin nflag = 1; npol = m_s2; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      m_pre = npre; m_cnt = ncnt; m_en = nen; m_hi = nhi; m_lo = nlo;
      m_flag = nflag; m_pol = npol;
    end
  end

  function automatic int m_read(logic [7:0] a);
    case (a)
      8'h00: return m_cnt;
      8'h04: return m_hi;
      8'h08: return m_lo;
      8'h0C: return m_en | (m_mode << 1) | (m_dpol << 3) | (m_ipol << 4) |
                    (m_scale << 9) | (m_div << 12);
      8'h10: return m_flag | (m_pol << 8);
      8'h14: return m_ier;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    #1;
    chk("R3 pwm_out", pwm_out, (m_en && m_mode < 2) ? ((m_cnt < m_lo) ? m_dpol : !m_dpol) : m_ipol);
    chk("R7 irq", irq, m_flag & m_ier);
  end

  task automatic wr(logic [7:0] a, int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2;
    chk(tag, int'(bus_rdata), m_read(a));
    bus_sel = 0;
  endtask

  task automatic rd_exp(logic [7:0] a, int exp, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2;
    chk(tag, int'(bus_rdata), exp);
    bus_sel = 0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ctl(int en, int md, int dp, int ip, int sc, int dv);
    return en | (md << 1) | (dp << 3) | (ip << 4) | (sc << 9) | (dv << 12);
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run(3);
    rst_n = 1;
    rd_exp(8'h0C, 0, "R8 reset ctrl");
    rd_exp(8'h00, 0, "R8 reset counter");
    rd_exp(8'h10, 0, "R6 reset status");
    // continuous
    wr(8'h04, 10); wr(8'h08, 3);
    rd_exp(8'h04, 10, "R8 period readback");
    wr(8'h0C, ctl(1, 1, 1, 0, 0, 0));
    run(37); rd(8'h00, "R2 continuous count");
    rd(8'h0C, "R2 continuous stays enabled");
    wr(8'h00, 16'h1234); rd(8'h00, "R8 counter read-only");
    // one-shot, inverted duty, idle high
    wr(8'h0C, 0);
    wr(8'h04, 5); wr(8'h08, 2);
    wr(8'h0C, ctl(1, 0, 0, 1, 0, 0));
    run(20);
    rd_exp(8'h0C, ctl(0, 0, 0, 1, 0, 0), "R2 one-shot self-clear");
    // prescaled continuous, divide by 4 then 128
    wr(8'h0C, ctl(1, 1, 1, 0, 1, 2));
    run(61); rd(8'h00, "R4 prescale by 4");
    wr(8'h0C, ctl(1, 1, 1, 0, 1, 7));
    run(300); rd(8'h00, "R4 prescale by 128");
    // disable holds
    wr(8'h0C, ctl(0, 1, 1, 0, 0, 0));
    rd(8'h00, "R1 hold a");
    run(25); rd(8'h00, "R1 hold b");
    // capture
    wr(8'h14, 1);
    wr(8'h0C, ctl(1, 2, 0, 0, 0, 0));
    run(4);
    cap_in = 1; run(7);
    cap_in = 0; run(12);
    cap_in = 1; run(5);
    rd(8'h04, "R5 high phase");
    rd(8'h08, "R5 low phase");
    rd(8'h10, "R6 status with level");
    wr(8'h10, 0); rd_exp(8'h10, 32'h101, "R6 write zero no effect");
    wr(8'h10, 1); rd_exp(8'h10, 32'h100, "R6 write one clears");
    cap_in = 0; run(6);
    rd(8'h04, "R5 second high phase");
    rd(8'h10, "R6 level low");
    wr(8'h14, 0); rd(8'h10, "R7 masked status");
    wr(8'h10, 1);
    // disabled capture ignores edges
    wr(8'h0C, ctl(0, 2, 0, 0, 0, 0));
    cap_in = 1; run(6); cap_in = 0; run(6);
    rd_exp(8'h10, 0, "R1 no flag while disabled");
    // saturation
    wr(8'h14, 1);
    wr(8'h0C, ctl(1, 2, 0, 0, 0, 0));
    run(66000);
    rd_exp(8'h00, 16'hFFFF, "R9 counter saturates");
    cap_in = 1; run(6);
    rd_exp(8'h08, 16'hFFFF, "R9 saturated low phase");
    rd(8'h10, "R6 final status");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule